// File: doc/BRIEF.md
# Bidirectional Host Parallel Channel Engine

This block is the host end of a loosely coupled, two-way byte channel on an eight-bit parallel link. Upstream logic fills a forward queue with bytes, each marked as ordinary data or as a command. The engine moves those bytes across the link with an interlocked strobe/acknowledge handshake. The level of a separate host line tells the peripheral whether the byte on the wires is data or a command. Each completed forward byte advances a transfer counter.

When upstream logic asks for the reverse direction, the engine first waits until the forward queue is empty and the link is quiet. It then turns off its data drivers and raises a turnaround request to the peer. It receives nothing until the peer grants the request. Once reverse is granted, each byte the peer strobes in is stored in a reverse queue, together with its data/command type, which is taken from the peer's acknowledge line. Command bytes are classified as a run-length count or a channel address. When the reverse queue is full, the peer is stalled. Dropping the request turns the link back to forward.

Top module: `duplex_port_engine`

## Requirements
- R1: A forward byte is placed on `pd_out` with `hack` high for data or low for command at least one clock before `hstrobe_n` falls, and both stay unchanged while `hstrobe_n` is low; `pd_oe` is high throughout.
- R2: A forward cycle starts only while `pack` is low; `hstrobe_n` returns high only in the clock after `pack` is seen high, and the next byte waits for `pack` to go low again.
- R3: `fwd_sent_cnt` increments by one in the same clock edge that raises `hstrobe_n`, and at no other time.
- R4: A turnaround starts only when the forward queue is empty and no forward cycle is open; `pd_oe` goes low at least one clock before `rev_req_n` goes low.
- R5: No reverse byte is accepted before `rev_ack_n` is low; `dir_is_reverse` goes high one clock after the grant is seen.
- R6: In reverse, `hack` rises one clock after `pstrobe_n` is seen low; the byte on `pd_in` is captured when `pstrobe_n` is seen high, and `hack` falls in that same edge if the reverse queue has room.
- R7: The reverse type comes from `pack` at capture (high = data, low = command). `rev_kind` reads 0 for data, 1 for a command with bit 7 clear (a run-length count in bits 6..0), and 2 for a command with bit 7 set (a channel address in bits 6..0). `rev_byte` carries all eight bits.
- R8: If the reverse queue is full when a capture occurs, `hack` stays high until a pop frees space, and the stalled byte is then stored behind the others with nothing lost.
- R9: Dropping `want_reverse` raises `rev_req_n` once no reverse cycle is open. `pd_oe` and forward transfers resume only after `rev_ack_n` is seen high.
- R10: `peer_data_avail` equals the inverse of `preq_n` as sampled on the previous clock.
- R11: After reset: `hstrobe_n`=1, `hack`=1, `rev_req_n`=1, `pd_oe`=1, `fwd_sent_cnt`=0, `fwd_full`=0, `rev_empty`=1, `dir_is_reverse`=0.
- R12: A push into a full forward queue is ignored; only the bytes accepted before it are transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_push | input | 1 | Write one byte into the forward queue |
| fwd_is_cmd | input | 1 | Marks the pushed byte as a command |
| fwd_byte | input | 8 | Pushed byte value |
| fwd_full | output | 1 | Forward queue full |
| rev_pop | input | 1 | Remove the head of the reverse queue |
| rev_byte | output | 8 | Head byte of the reverse queue |
| rev_kind | output | 2 | Head classification: 0 data, 1 run-length, 2 channel |
| rev_empty | output | 1 | Reverse queue empty |
| want_reverse | input | 1 | Level request for reverse direction |
| dir_is_reverse | output | 1 | Reverse direction granted and active |
| fwd_sent_cnt | output | CNT_W | Count of completed forward bytes |
| peer_data_avail | output | 1 | Peer reports reverse data pending |
| hstrobe_n | output | 1 | Host strobe for forward bytes, active low |
| hack | output | 1 | Forward type flag / reverse acknowledge |
| rev_req_n | output | 1 | Turnaround request, active low |
| pd_out | output | 8 | Data driven onto the link |
| pd_oe | output | 1 | Link data driver enable |
| pd_in | input | 8 | Data received from the link |
| pstrobe_n | input | 1 | Peer strobe for reverse bytes, active low |
| pack | input | 1 | Peer acknowledge / reverse type flag |
| rev_ack_n | input | 1 | Peer turnaround grant, active low |
| preq_n | input | 1 | Peer data-pending request, active low |

## Verification
The assertions check on every cycle the local ordering rules of the handshakes. The host strobe rises only after the peer acknowledge, the type and data stay stable while the strobe is low, and the counter steps exactly on the strobe's rising edge. They also check that the drivers are off before and during the turnaround request, that the reverse acknowledge follows the peer strobe and is released only when there is room, and that driving resumes only after the grant is withdrawn. The bench scenarios show the behaviours that span whole exchanges: the byte values and type flags that reach each side, the hold-off while the forward queue still has bytes, a stray peer strobe ignored before the grant, the order of queued bytes across a full-queue stall, the dropped push into a full queue, and the classification of command bytes.

// File: rtl/dpe_pkg.sv
package dpe_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              is_cmd;
        logic [BYTE_W-1:0] value;
    } pbyte_t;

    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_RUN  = 2'd1,
        K_CHAN = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_SETUP,
        F_STROBE,
        F_RELEASE
    } fwd_st_e;

    typedef enum logic [1:0] {
        R_READY,
        R_ACKED,
        R_HOLD
    } rev_st_e;

    typedef enum logic [2:0] {
        D_FWD,
        D_QUIET,
        D_REQ,
        D_REV,
        D_RET
    } dir_st_e;

    // Command bytes use bit 7 to pick channel address versus run-length count.
    function automatic kind_e classify(pbyte_t b);
        if (!b.is_cmd)
            return K_DATA;
        return b.value[BYTE_W-1] ? K_CHAN : K_RUN;
    endfunction

endpackage

// File: rtl/dpe_fifo.sv
module dpe_fifo
    import dpe_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  pbyte_t wr_item,
    input  logic   pop,
    output pbyte_t rd_item,
    output logic   full,
    output logic   empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    pbyte_t         mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [CW-1:0]  cnt;
    logic           do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_item = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wp] <= wr_item;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push)
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R12: occupancy never exceeds the depth
    a_r12_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R12: a full queue without a pop keeps its occupancy despite pushes
    a_r12_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);

endmodule

// File: rtl/dpe_fwd_hs.sv
module dpe_fwd_hs
    import dpe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  pbyte_t            head,
    input  logic              head_valid,
    output logic              pop,
    output logic              strobe_n,
    output logic              tag_hi,
    output logic [BYTE_W-1:0] dout,
    input  logic              pack,
    output logic              busy,
    output logic [CNT_W-1:0]  sent_cnt
);
    fwd_st_e st;

    assign pop  = (st == F_IDLE) && en && head_valid && !pack;
    assign busy = (st != F_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= F_IDLE;
            strobe_n <= 1'b1;
            tag_hi   <= 1'b1;
            dout     <= '0;
            sent_cnt <= '0;
        end else begin
            case (st)
                F_IDLE: if (pop) begin
                    dout   <= head.value;
                    tag_hi <= !head.is_cmd;
                    st     <= F_SETUP;
                end
                F_SETUP: begin
                    strobe_n <= 1'b0;
                    st       <= F_STROBE;
                end
                F_STROBE: if (pack) begin
                    strobe_n <= 1'b1;
                    sent_cnt <= sent_cnt + 1'b1;
                    st       <= F_RELEASE;
                end
                F_RELEASE: if (!pack)
                    st <= F_IDLE;
                default: st <= F_IDLE;
            endcase
        end
    end

    // R1: type flag and data hold while the strobe is low
    a_r1_stable_in_strobe: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> ($stable(tag_hi) && $stable(dout)));

    // R2: strobe is released only after the peer acknowledged
    a_r2_rise_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_n) |-> $past(pack));

    // R3: counter steps by one on the releasing edge
    a_r3_count_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_n) |-> (sent_cnt == CNT_W'($past(sent_cnt) + 1'b1)));

    // R3: counter holds on every other edge
    a_r3_count_still: assert property (@(posedge clk) disable iff (rst)
        !$rose(strobe_n) |-> $stable(sent_cnt));

endmodule

// File: rtl/dpe_rev_hs.sv
module dpe_rev_hs
    import dpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              pstrobe_n,
    input  logic              pack,
    input  logic [BYTE_W-1:0] din,
    input  logic              fifo_full,
    output logic              push,
    output pbyte_t            item,
    output logic              hack,
    output logic              idle
);
    rev_st_e st;
    pbyte_t  held;
    pbyte_t  live;

    assign live = '{is_cmd: !pack, value: din};
    assign idle = (st == R_READY);

    always_comb begin
        push = 1'b0;
        item = held;
        case (st)
            R_ACKED: if (pstrobe_n && !fifo_full) begin
                push = 1'b1;
                item = live;
            end
            R_HOLD: if (!fifo_full)
                push = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= R_READY;
            hack <= 1'b0;
            held <= '0;
        end else begin
            case (st)
                R_READY: if (en && !pstrobe_n) begin
                    hack <= 1'b1;
                    st   <= R_ACKED;
                end
                R_ACKED: if (pstrobe_n) begin
                    if (!fifo_full) begin
                        hack <= 1'b0;
                        st   <= R_READY;
                    end else begin
                        held <= live;
                        st   <= R_HOLD;
                    end
                end
                R_HOLD: if (!fifo_full) begin
                    hack <= 1'b0;
                    st   <= R_READY;
                end
                default: st <= R_READY;
            endcase
        end
    end

    // R6: acknowledge follows a low peer strobe
    a_r6_ack_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(hack) |-> $past(!pstrobe_n));

    // R8: acknowledge released only while the queue has room
    a_r8_release_with_room: assert property (@(posedge clk) disable iff (rst)
        $fell(hack) |-> $past(!fifo_full));

endmodule

// File: rtl/duplex_port_engine.sv
module duplex_port_engine
    import dpe_pkg::*;
#(
    parameter int FWD_DEPTH = 4,
    parameter int REV_DEPTH = 4,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fwd_push,
    input  logic             fwd_is_cmd,
    input  logic [7:0]       fwd_byte,
    output logic             fwd_full,
    input  logic             rev_pop,
    output logic [7:0]       rev_byte,
    output logic [1:0]       rev_kind,
    output logic             rev_empty,
    input  logic             want_reverse,
    output logic             dir_is_reverse,
    output logic [CNT_W-1:0] fwd_sent_cnt,
    output logic             peer_data_avail,
    output logic             hstrobe_n,
    output logic             hack,
    output logic             rev_req_n,
    output logic [7:0]       pd_out,
    output logic             pd_oe,
    input  logic [7:0]       pd_in,
    input  logic             pstrobe_n,
    input  logic             pack,
    input  logic             rev_ack_n,
    input  logic             preq_n
);
    dir_st_e dst;

    pbyte_t  fwd_head, rev_head, rev_item;
    logic    fwd_empty, fwd_pop, fwd_busy, fwd_tag;
    logic    rev_full, rev_push, rev_hack, rev_idle;

    dpe_fifo #(.DEPTH(FWD_DEPTH)) fwd_q_i (
        .clk     (clk),
        .rst     (rst),
        .push    (fwd_push),
        .wr_item ('{is_cmd: fwd_is_cmd, value: fwd_byte}),
        .pop     (fwd_pop),
        .rd_item (fwd_head),
        .full    (fwd_full),
        .empty   (fwd_empty)
    );

    dpe_fwd_hs #(.CNT_W(CNT_W)) fwd_hs_i (
        .clk        (clk),
        .rst        (rst),
        .en         (dst == D_FWD),
        .head       (fwd_head),
        .head_valid (!fwd_empty),
        .pop        (fwd_pop),
        .strobe_n   (hstrobe_n),
        .tag_hi     (fwd_tag),
        .dout       (pd_out),
        .pack       (pack),
        .busy       (fwd_busy),
        .sent_cnt   (fwd_sent_cnt)
    );

    dpe_rev_hs rev_hs_i (
        .clk       (clk),
        .rst       (rst),
        .en        (dst == D_REV),
        .pstrobe_n (pstrobe_n),
        .pack      (pack),
        .din       (pd_in),
        .fifo_full (rev_full),
        .push      (rev_push),
        .item      (rev_item),
        .hack      (rev_hack),
        .idle      (rev_idle)
    );

    dpe_fifo #(.DEPTH(REV_DEPTH)) rev_q_i (
        .clk     (clk),
        .rst     (rst),
        .push    (rev_push),
        .wr_item (rev_item),
        .pop     (rev_pop),
        .rd_item (rev_head),
        .full    (rev_full),
        .empty   (rev_empty)
    );

    assign rev_byte       = rev_head.value;
    assign rev_kind       = classify(rev_head);
    assign dir_is_reverse = (dst == D_REV);
    assign hack           = (dst == D_REV) ? rev_hack : fwd_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            dst             <= D_FWD;
            pd_oe           <= 1'b1;
            rev_req_n       <= 1'b1;
            peer_data_avail <= 1'b0;
        end else begin
            peer_data_avail <= !preq_n;
            case (dst)
                D_FWD: if (want_reverse && fwd_empty && !fwd_busy) begin
                    pd_oe <= 1'b0;
                    dst   <= D_QUIET;
                end
                D_QUIET: begin
                    rev_req_n <= 1'b0;
                    dst       <= D_REQ;
                end
                D_REQ: if (!rev_ack_n)
                    dst <= D_REV;
                D_REV: if (!want_reverse && rev_idle && pstrobe_n) begin
                    rev_req_n <= 1'b1;
                    dst       <= D_RET;
                end
                D_RET: if (rev_ack_n) begin
                    pd_oe <= 1'b1;
                    dst   <= D_FWD;
                end
                default: dst <= D_FWD;
            endcase
        end
    end

    // R4: drivers are off whenever the turnaround request is active
    a_r4_quiet_during_req: assert property (@(posedge clk) disable iff (rst)
        !rev_req_n |-> !pd_oe);

    // R4: drivers went off at least one clock before the request
    a_r4_quiet_before_req: assert property (@(posedge clk) disable iff (rst)
        $fell(rev_req_n) |-> $past(!pd_oe));

    // R5: reverse is entered only on a seen grant
    a_r5_grant_first: assert property (@(posedge clk) disable iff (rst)
        $rose(dir_is_reverse) |-> $past(!rev_ack_n));

    // R9: driving resumes only after the grant is withdrawn
    a_r9_drive_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_oe) |-> ($past(rev_ack_n) && rev_req_n));

endmodule

// File: tb/duplex_port_engine_tb_top.sv
module duplex_port_engine_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fwd_push = 0, fwd_is_cmd = 0;
    logic [7:0]    fwd_byte = 0;
    logic          fwd_full;
    logic          rev_pop = 0;
    logic [7:0]    rev_byte;
    logic [1:0]    rev_kind;
    logic          rev_empty;
    logic          want_reverse = 0;
    logic          dir_is_reverse;
    logic [CW-1:0] fwd_sent_cnt;
    logic          peer_data_avail;
    logic          hstrobe_n, hack, rev_req_n, pd_oe;
    logic [7:0]    pd_out;
    logic [7:0]    pd_in = 0;
    logic          pstrobe_n = 1, pack = 0, rev_ack_n = 1, preq_n = 1;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    duplex_port_engine #(.FWD_DEPTH(4), .REV_DEPTH(4), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst),
        .fwd_push(fwd_push), .fwd_is_cmd(fwd_is_cmd), .fwd_byte(fwd_byte), .fwd_full(fwd_full),
        .rev_pop(rev_pop), .rev_byte(rev_byte), .rev_kind(rev_kind), .rev_empty(rev_empty),
        .want_reverse(want_reverse), .dir_is_reverse(dir_is_reverse),
        .fwd_sent_cnt(fwd_sent_cnt), .peer_data_avail(peer_data_avail),
        .hstrobe_n(hstrobe_n), .hack(hack), .rev_req_n(rev_req_n),
        .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
        .pstrobe_n(pstrobe_n), .pack(pack), .rev_ack_n(rev_ack_n), .preq_n(preq_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // which: 0 hstrobe_n, 1 hack, 2 rev_req_n, 3 pd_oe, 4 dir_is_reverse
    task automatic wait_sig(input int which, input logic v, input string req);
        logic cur;
        for (int t = 0; t < 200; t++) begin
            case (which)
                0: cur = hstrobe_n;
                1: cur = hack;
                2: cur = rev_req_n;
                3: cur = pd_oe;
                default: cur = dir_is_reverse;
            endcase
            if (cur === v) return;
            tick();
        end
        check(req, "wait timeout", 32'(cur), 32'(v));
    endtask

    task automatic push_fwd(input logic cmd, input logic [7:0] b);
        fwd_push = 1; fwd_is_cmd = cmd; fwd_byte = b;
        tick();
        fwd_push = 0;
    endtask

    // Peripheral side of one forward byte
    task automatic accept(input logic [7:0] b, input logic tag, input int cnt_after);
        wait_sig(0, 1'b0, "R2");
        check("R1", "pd_out", 32'(pd_out), 32'(b));
        check("R1", "hack type", 32'(hack), 32'(tag));
        check("R1", "pd_oe", 32'(pd_oe), 32'd1);
        check("R3", "count before rise", 32'(fwd_sent_cnt), 32'(cnt_after - 1));
        tick(3);
        check("R2", "strobe held until ack", 32'(hstrobe_n), 32'd0);
        pack = 1;
        tick();
        check("R2", "strobe released", 32'(hstrobe_n), 32'd1);
        check("R3", "count at rise", 32'(fwd_sent_cnt), 32'(cnt_after));
        pack = 0;
    endtask

    // Peripheral side of one reverse byte
    task automatic send(input logic [7:0] b, input logic is_data, input logic stall);
        pd_in = b; pack = is_data;
        tick();
        pstrobe_n = 0;
        tick();
        check("R6", "ack after peer strobe", 32'(hack), 32'd1);
        pstrobe_n = 1;
        tick();
        if (!stall) begin
            check("R6", "ack drop at capture", 32'(hack), 32'd0);
        end else begin
            tick(4);
            check("R8", "ack held while full", 32'(hack), 32'd1);
        end
    endtask

    task automatic pop_expect(input logic [7:0] b, input logic [1:0] k, input string req);
        check(req, "rev_empty", 32'(rev_empty), 32'd0);
        check(req, "rev_byte", 32'(rev_byte), 32'(b));
        check(req, "rev_kind", 32'(rev_kind), 32'(k));
        rev_pop = 1;
        tick();
        rev_pop = 0;
    endtask

    task automatic t_reset();
        check("R11", "hstrobe_n", 32'(hstrobe_n), 32'd1);
        check("R11", "hack", 32'(hack), 32'd1);
        check("R11", "rev_req_n", 32'(rev_req_n), 32'd1);
        check("R11", "pd_oe", 32'(pd_oe), 32'd1);
        check("R11", "count", 32'(fwd_sent_cnt), 32'd0);
        check("R11", "fwd_full", 32'(fwd_full), 32'd0);
        check("R11", "rev_empty", 32'(rev_empty), 32'd1);
        check("R11", "dir", 32'(dir_is_reverse), 32'd0);
    endtask

    task automatic t_peer_avail();
        preq_n = 0;
        tick();
        check("R10", "avail set", 32'(peer_data_avail), 32'd1);
        preq_n = 1;
        tick();
        check("R10", "avail clear", 32'(peer_data_avail), 32'd0);
    endtask

    task automatic t_forward();
        pack = 1;
        push_fwd(1'b0, 8'hA5);
        push_fwd(1'b1, 8'h05);
        push_fwd(1'b1, 8'h83);
        push_fwd(1'b0, 8'h5A);
        check("R12", "fwd_full", 32'(fwd_full), 32'd1);
        push_fwd(1'b0, 8'hFF);
        tick(4);
        check("R2", "no start while pack high", 32'(hstrobe_n), 32'd1);
        pack = 0;
        accept(8'hA5, 1'b1, 1);
        accept(8'h05, 1'b0, 2);
        accept(8'h83, 1'b0, 3);
        accept(8'h5A, 1'b1, 4);
        tick(10);
        check("R12", "dropped push not sent", 32'(hstrobe_n), 32'd1);
        check("R12", "final count", 32'(fwd_sent_cnt), 32'd4);
    endtask

    task automatic t_turn();
        logic prev_oe;
        pack = 1;
        push_fwd(1'b0, 8'hC3);
        want_reverse = 1;
        tick(6);
        check("R4", "no request with queued byte", 32'(rev_req_n), 32'd1);
        check("R4", "still driving", 32'(pd_oe), 32'd1);
        pack = 0;
        accept(8'hC3, 1'b1, 5);
        prev_oe = pd_oe;
        for (int t = 0; t < 50 && rev_req_n !== 1'b0; t++) begin
            prev_oe = pd_oe;
            tick();
        end
        check("R4", "request raised", 32'(rev_req_n), 32'd0);
        check("R4", "drivers off before request", 32'(prev_oe), 32'd0);
        pstrobe_n = 0;
        tick(2);
        pstrobe_n = 1;
        tick(3);
        check("R5", "no capture before grant", 32'(rev_empty), 32'd1);
        check("R5", "not reverse before grant", 32'(dir_is_reverse), 32'd0);
        rev_ack_n = 0;
        tick();
        check("R5", "reverse after grant", 32'(dir_is_reverse), 32'd1);
        check("R5", "hack ready low", 32'(hack), 32'd0);
        check("R4", "drivers stay off", 32'(pd_oe), 32'd0);
    endtask

    task automatic t_reverse();
        send(8'h3C, 1'b1, 1'b0);
        send(8'h11, 1'b0, 1'b0);
        send(8'h9F, 1'b0, 1'b0);
        pop_expect(8'h3C, 2'd0, "R7");
        pop_expect(8'h11, 2'd1, "R7");
        pop_expect(8'h9F, 2'd2, "R7");
        check("R7", "drained", 32'(rev_empty), 32'd1);
    endtask

    task automatic t_full();
        send(8'h01, 1'b1, 1'b0);
        send(8'h02, 1'b0, 1'b0);
        send(8'h03, 1'b1, 1'b0);
        send(8'h04, 1'b1, 1'b0);
        send(8'hE7, 1'b0, 1'b1);
        pop_expect(8'h01, 2'd0, "R8");
        tick(2);
        check("R8", "ack released after room", 32'(hack), 32'd0);
        pop_expect(8'h02, 2'd1, "R8");
        pop_expect(8'h03, 2'd0, "R8");
        pop_expect(8'h04, 2'd0, "R8");
        pop_expect(8'hE7, 2'd2, "R8");
        check("R8", "drained", 32'(rev_empty), 32'd1);
    endtask

    task automatic t_return();
        pack = 0;
        want_reverse = 0;
        tick(2);
        check("R9", "request released", 32'(rev_req_n), 32'd1);
        push_fwd(1'b0, 8'h77);
        tick(4);
        check("R9", "no drive before grant withdrawn", 32'(pd_oe), 32'd0);
        check("R9", "no strobe before grant withdrawn", 32'(hstrobe_n), 32'd1);
        rev_ack_n = 1;
        tick(2);
        check("R9", "driving again", 32'(pd_oe), 32'd1);
        check("R9", "forward direction", 32'(dir_is_reverse), 32'd0);
        accept(8'h77, 1'b1, 6);
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick();
        t_reset();
        t_peer_avail();
        t_forward();
        t_turn();
        t_reverse();
        t_full();
        t_return();
        tick(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule